// File: doc/BRIEF.md
# Display-Memory Command Slave on a Two-Wire Serial Bus

This block is an I2C slave that lets a bus master reach a twelve-byte display memory. After the address byte of a write transfer, the first byte is a combined command register. It carries a display-off flag, a frame-rate select, a blink-rate select and a four-bit memory pointer. Every further byte of the same write goes into the memory at the pointer, and the pointer then steps forward. A read can follow a command write through a repeated START. A read can also begin on its own, using the pointer that an earlier command left behind. In both cases the read bytes come from successive pointer positions until the master answers with NACK.

The pointer runs from 0 to 11 and wraps from 11 back to 0. A command that tries to load 12 to 15 loads 0 instead. The bus pins are modelled as open-drain: `sda_oe` high pulls SDA low. Both lines are resynchronised to the system clock, and START and STOP are recognised as SDA edges while SCL is high. The memory itself sits outside the block. The block issues a one-cycle write strobe with address and data, and it reads back through a combinational read port addressed by the pointer.

The controller has these states: IDLE, ADDR (shifting the address), ADDR_ACK, CMD (shifting the command), CMD_ACK, WDATA (shifting a data byte), WDATA_ACK, RDATA (sending a byte), RACK (taking the master's acknowledge) and SKIP (waiting for the next START). Its transitions are as follows.
- A STOP sends every state to IDLE, and a START sends every state to ADDR.
- After eight address bits, ADDR goes to ADDR_ACK on a match and to SKIP on a mismatch.
- ADDR_ACK goes to RDATA for a read and to CMD for a write.
- CMD goes to CMD_ACK, and CMD_ACK goes to WDATA.
- WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA.
- RDATA goes to RACK after eight bits.
- RACK goes to RDATA when the master sends ACK and to SKIP when it sends NACK.

Top module: `dispmem_i2c_slave`

## Requirements
- R1: After reset, `disp_off`, `frame_sel`, `blink_sel` and `mem_raddr` are all 0, `sda_oe` is 0 and `mem_we` is 0.
- R2: The slave acknowledges an address byte whose upper seven bits are 0111001 by pulling SDA low in the ninth clock. Bit 0 of that byte selects the direction: 0 is write, 1 is read. For any other address the slave never pulls SDA low before the next START.
- R3: In a write, the first byte after the address is acknowledged and loads the command register. Bit 7 goes to `disp_off`, bits 6:5 to `frame_sel`, bit 4 to `blink_sel` and bits 3:0 to the pointer (`mem_raddr`). The command fields change at no other time.
- R4: Each byte after the command byte in a write is acknowledged. It produces a one-cycle `mem_we` with `mem_waddr` equal to the pointer and `mem_wdata` equal to the byte, received MSB first. The pointer then advances by one.
- R5: The pointer never exceeds 11, and advancing it from 11 gives 0.
- R6: A command byte whose bits 3:0 are 12 to 15 loads the pointer with 0.
- R7: A read that follows a command write through a repeated START sends memory bytes MSB first, starting at the loaded pointer. The pointer advances after each byte. SDA changes only while SCL is low.
- R8: A read that begins directly after START with no command byte starts at the pointer value left by earlier traffic.
- R9: After the master NACKs a read byte, the slave leaves SDA released until the next START.
- R10: A STOP at any point releases SDA and leaves the command fields as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| mem_we | output | 1 | One-cycle display memory write strobe |
| mem_waddr | output | 4 | Display memory write address |
| mem_wdata | output | 8 | Display memory write data |
| mem_raddr | output | 4 | Display memory read address (the pointer) |
| mem_rdata | input | 8 | Display memory read data at `mem_raddr` |
| disp_off | output | 1 | 1 blanks the whole display |
| frame_sel | output | 2 | Frame-rate select |
| blink_sel | output | 1 | Blink-rate select |

## Verification
A wrong controller state shows up on SDA within one bit time. Typical signs are an acknowledge that is missing or misplaced, a read bit driven during an acknowledge slot, or the line held low after a NACK. A wrong bit count or shift register shows up as a strobe at the wrong bus clock, or as wrong `mem_wdata` or read bytes, on the byte where the error occurs. A pointer fault may stay hidden until the transfer after it. For that reason the bench checks `mem_raddr` after every transfer and runs bursts across the wrap from 11 to 0.

// File: rtl/dispmem_pkg.sv
package dispmem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } bus_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Lines idle high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // SDA edges count as START or STOP only while SCL is high in both samples.
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cmd_ptr_reg.sv
module cmd_ptr_reg #(
    parameter int ADDR_W    = 4,
    parameter int LAST_ADDR = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic [7:0]        cmd_byte,
    input  logic              ptr_inc,
    output logic              disp_off,
    output logic [1:0]        frame_sel,
    output logic              blink_sel,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST = LAST_ADDR[ADDR_W-1:0];

    logic [ADDR_W-1:0] ptr_field;
    logic [ADDR_W-1:0] ptr_load_val;
    logic [ADDR_W-1:0] ptr_step_val;

    assign ptr_field    = cmd_byte[ADDR_W-1:0];
    // An out-of-range pointer value is replaced by 0.
    assign ptr_load_val = (ptr_field > LAST) ? '0 : ptr_field;
    assign ptr_step_val = (ptr == LAST) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_off  <= 1'b0;
            frame_sel <= 2'b00;
            blink_sel <= 1'b0;
            ptr       <= '0;
        end else if (cmd_load) begin
            disp_off  <= cmd_byte[7];
            frame_sel <= cmd_byte[6:5];
            blink_sel <= cmd_byte[4];
            ptr       <= ptr_load_val;
        end else if (ptr_inc) begin
            ptr       <= ptr_step_val;
        end
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import dispmem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0111001,
    parameter int         ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [7:0]        mem_rdata,
    output logic              sda_oe,
    output logic              cmd_load,
    output logic [7:0]        cmd_byte,
    output logic              ptr_inc,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata
);
    bus_state_t  state_q;
    bus_state_t  state_d;
    logic [3:0]  bit_cnt;
    logic [7:0]  shreg;
    logic [6:0]  tx_q;
    logic        m_ack_q;
    logic        addr_match;
    logic        byte_end;

    assign addr_match = (shreg[7:1] == DEV_ADDR);
    assign byte_end   = scl_fall && (bit_cnt == 4'd8);
    assign cmd_byte   = shreg;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: state_d = state_q;
                ST_ADDR:      if (byte_end) state_d = addr_match ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall) state_d = shreg[0] ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_end) state_d = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_end) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == 4'd7) state_d = ST_RACK;
                ST_RACK:      if (scl_fall) state_d = m_ack_q ? ST_RDATA : ST_SKIP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            cmd_load  <= 1'b0;
            ptr_inc   <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            tx_q      <= '0;
            m_ack_q   <= 1'b0;
        end else begin
            cmd_load <= 1'b0;
            ptr_inc  <= 1'b0;
            mem_we   <= 1'b0;
            if (stop_det || start_det) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_end) begin
                            bit_cnt <= '0;
                            if (state_q == ST_ADDR) begin
                                sda_oe <= addr_match;
                            end else begin
                                sda_oe <= 1'b1;
                            end
                            if (state_q == ST_CMD) cmd_load <= 1'b1;
                            if (state_q == ST_WDATA) begin
                                mem_we    <= 1'b1;
                                mem_waddr <= ptr;
                                mem_wdata <= shreg;
                                ptr_inc   <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (shreg[0]) begin
                                tx_q   <= mem_rdata[6:0];
                                sda_oe <= ~mem_rdata[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe  <= 1'b0;
                                ptr_inc <= 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + 4'd1;
                                sda_oe  <= ~tx_q[6];
                                tx_q    <= {tx_q[5:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) m_ack_q <= ~sda_s;
                        if (scl_fall && m_ack_q) begin
                            bit_cnt <= '0;
                            tx_q    <= mem_rdata[6:0];
                            sda_oe  <= ~mem_rdata[7];
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dispmem_i2c_slave.sv
module dispmem_i2c_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b0111001,
    parameter int         DEPTH       = 12,
    parameter int         ADDR_W      = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic              disp_off,
    output logic [1:0]        frame_sel,
    output logic              blink_sel
);
    localparam int LAST_ADDR = DEPTH - 1;

    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       cmd_load;
    logic [7:0] cmd_byte;
    logic       ptr_inc;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ptr       (mem_raddr),
        .mem_rdata (mem_rdata),
        .sda_oe    (sda_oe),
        .cmd_load  (cmd_load),
        .cmd_byte  (cmd_byte),
        .ptr_inc   (ptr_inc),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    cmd_ptr_reg #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_load  (cmd_load),
        .cmd_byte  (cmd_byte),
        .ptr_inc   (ptr_inc),
        .disp_off  (disp_off),
        .frame_sel (frame_sel),
        .blink_sel (blink_sel),
        .ptr       (mem_raddr)
    );

endmodule

// File: rtl/dispmem_i2c_chk.sv
module dispmem_i2c_chk #(
    parameter int LAST_ADDR = 11,
    parameter int AW        = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_in,
    input logic          sda_oe,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr,
    input logic [AW-1:0] mem_raddr,
    input logic          disp_off,
    input logic [1:0]    frame_sel,
    input logic          blink_sel,
    input logic          cmd_load,
    input logic          stop_det
);
    localparam logic [AW-1:0] LAST = LAST_ADDR[AW-1:0];

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_raddr <= LAST);

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R5
    wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_raddr == (($past(mem_waddr) == LAST) ? '0 : $past(mem_waddr) + 1'b1)));

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_load |=> $stable({disp_off, frame_sel, blink_sel}));

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R7
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_in);

endmodule

bind dispmem_i2c_slave dispmem_i2c_chk #(.LAST_ADDR(LAST_ADDR), .AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_raddr (mem_raddr),
    .disp_off  (disp_off),
    .frame_sel (frame_sel),
    .blink_sel (blink_sel),
    .cmd_load  (cmd_load),
    .stop_det  (stop_det)
);

// File: tb/sim_dispmem_i2c_slave.sv
module sim_dispmem_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 40;
    localparam int QTR  = 4;
    localparam logic [7:0] ADDR_W_BYTE = 8'h72;
    localparam logic [7:0] ADDR_R_BYTE = 8'h73;
    localparam int NVEC = 6;
    // {command byte, data byte}
    localparam logic [15:0] VEC [NVEC] = '{16'h05A1, 16'hEB3C, 16'h3D77,
                                           16'h5F12, 16'h0C99, 16'h1A44};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe, mem_we, disp_off, blink_sel;
    logic [3:0] mem_waddr, mem_raddr;
    logic [7:0] mem_wdata, mem_rdata;
    logic [1:0] frame_sel;
    logic [7:0] mem_model [16];
    logic [3:0] wa_log [16];
    logic [7:0] wd_log [16];
    int         wr_total = 0;
    logic       oe_seen = 1'b0;
    logic       oe_watch = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign mem_rdata = mem_model[mem_raddr];

    dispmem_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .disp_off(disp_off), .frame_sel(frame_sel), .blink_sel(blink_sel)
    );

    initial begin
        for (int i = 0; i < 16; i++) mem_model[i] = 8'h30 + 8'(i * 13);
    end

    always @(posedge clk) begin
        if (mem_we) begin
            mem_model[mem_waddr] <= mem_wdata;
            wa_log[wr_total[3:0]] <= mem_waddr;
            wd_log[wr_total[3:0]] <= mem_wdata;
            wr_total <= wr_total + 1;
        end
        if (oe_watch && sda_oe) oe_seen <= 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HALF);
            scl_m = 1'b1; tick(HALF);
            scl_m = 1'b0; tick(QTR);
        end
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF/2);
        ack = ~sda_line; tick(HALF/2);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl_m = 1'b1; tick(HALF/2);
            b[i] = sda_line; tick(HALF/2);
            scl_m = 1'b0; tick(QTR);
        end
        sda_m = ~give_ack; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        scl_m = 1'b0; tick(QTR);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        logic [3:0] p;
        logic [3:0] nxt;
        logic [7:0] cmd;
        int         base;
        logic [3:0] ep;
        logic [7:0] exp_b;

        tick(5);
        // R1 reset state
        chk("R1 disp_off", int'(disp_off), 0);
        chk("R1 frame_sel", int'(frame_sel), 0);
        chk("R1 blink_sel", int'(blink_sel), 0);
        chk("R1 ptr", int'(mem_raddr), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(10);
        chk("R1 mem_we", int'(mem_we), 0);

        // Table walk: command + one data byte per vector
        for (int v = 0; v < NVEC; v++) begin
            cmd = VEC[v][15:8];
            p   = (cmd[3:0] > 4'd11) ? 4'd0 : cmd[3:0];
            nxt = (p == 4'd11) ? 4'd0 : p + 4'd1;
            bus_start;
            send_byte(ADDR_W_BYTE, ack); chk("R2 addr ack", int'(ack), 1);
            send_byte(cmd, ack);         chk("R3 cmd ack", int'(ack), 1);
            base = wr_total;
            send_byte(VEC[v][7:0], ack); chk("R4 data ack", int'(ack), 1);
            bus_stop;
            tick(10);
            chk("R4 write count", wr_total - base, 1);
            chk((cmd[3:0] > 4'd11) ? "R6 forced ptr waddr" : "R4 waddr",
                int'(wa_log[base[3:0]]), int'(p));
            chk("R4 wdata", int'(wd_log[base[3:0]]), int'(VEC[v][7:0]));
            chk("R3 disp_off", int'(disp_off), int'(cmd[7]));
            chk("R3 frame_sel", int'(frame_sel), int'(cmd[6:5]));
            chk("R3 blink_sel", int'(blink_sel), int'(cmd[4]));
            chk((p == 4'd11) ? "R5 wrap ptr" : "R4 ptr advance", int'(mem_raddr), int'(nxt));
        end

        // R4 R5 burst across the wrap
        bus_start;
        send_byte(ADDR_W_BYTE, ack);
        send_byte(8'h0A, ack);
        base = wr_total;
        send_byte(8'hD1, ack);
        send_byte(8'hD2, ack);
        send_byte(8'hD3, ack); chk("R4 burst ack", int'(ack), 1);
        bus_stop;
        tick(10);
        chk("R4 burst count", wr_total - base, 3);
        chk("R4 burst addr0", int'(wa_log[base[3:0]]), 10);
        chk("R5 burst addr1", int'(wa_log[4'(base + 1)]), 11);
        chk("R5 burst addr2 wrap", int'(wa_log[4'(base + 2)]), 0);
        chk("R4 burst data2", int'(wd_log[4'(base + 2)]), 8'hD3);
        chk("R5 ptr after burst", int'(mem_raddr), 1);

        // R2 foreign address: no acknowledge, no drive, no writes
        oe_seen = 1'b0; oe_watch = 1'b1;
        base = wr_total;
        bus_start;
        send_byte(8'h74, ack); chk("R2 foreign no ack", int'(ack), 0);
        send_byte(8'h00, ack); chk("R2 foreign data no ack", int'(ack), 0);
        bus_stop;
        tick(10);
        oe_watch = 1'b0;
        chk("R2 foreign never drove", int'(oe_seen), 0);
        chk("R2 foreign no write", wr_total - base, 0);
        chk("R2 foreign ptr kept", int'(mem_raddr), 1);

        // R7 combined read through repeated start, R9 release after NACK
        bus_start;
        send_byte(ADDR_W_BYTE, ack);
        send_byte(8'h0A, ack);
        bus_start;
        send_byte(ADDR_R_BYTE, ack); chk("R7 read addr ack", int'(ack), 1);
        ep = 4'd10;
        for (int k = 0; k < 3; k++) begin
            exp_b = mem_model[ep];
            recv_byte(k < 2, rb);
            chk("R7 read byte", int'(rb), int'(exp_b));
            ep = (ep == 4'd11) ? 4'd0 : ep + 4'd1;
        end
        tick(HALF);
        scl_m = 1'b1; tick(HALF/2);
        chk("R9 line released after NACK", int'(sda_line), 1);
        chk("R9 sda_oe after NACK", int'(sda_oe), 0);
        tick(HALF/2);
        scl_m = 1'b0; tick(QTR);
        bus_stop;
        tick(10);
        chk("R7 ptr after read", int'(mem_raddr), 1);

        // R8 read from preset pointer
        bus_start;
        send_byte(ADDR_R_BYTE, ack); chk("R8 read addr ack", int'(ack), 1);
        exp_b = mem_model[1];
        recv_byte(1'b0, rb);
        chk("R8 preset read byte", int'(rb), int'(exp_b));
        bus_stop;
        tick(10);
        chk("R8 ptr advanced", int'(mem_raddr), 2);

        // R10 stop in the middle of a command byte
        bus_start;
        send_byte(ADDR_W_BYTE, ack);
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b1; tick(HALF);
            scl_m = 1'b1; tick(HALF);
            scl_m = 1'b0; tick(QTR);
        end
        bus_stop;
        tick(10);
        chk("R10 sda released", int'(sda_oe), 0);
        chk("R10 disp_off kept", int'(disp_off), 0);
        chk("R10 frame_sel kept", int'(frame_sel), 0);
        chk("R10 ptr kept", int'(mem_raddr), 2);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule